// File: doc/BRIEF.md
# Colour-Plane Word Packer for Field-Sequential Display Writes

This block sits between a pixel stream and the frame-store writer of a field-sequential colour display. It takes one 24-bit pixel per clock, split into 8-bit red, green and blue samples, together with a valid qualifier. Each colour has its own byte-wide shift path. Every four accepted pixels, each path yields a 32-bit word that holds four samples of that colour. The display is loaded four pixels at a time, so this is the width that the memory side consumes.

When the fourth pixel of a group is accepted, the three finished words are copied into holding registers. A small state machine then releases them one per clock in a fixed rotation: red, then green, then blue, then one empty cycle. During the release, three one-hot select flags mark which colour is on the output. Each word carries a valid strobe and a 2-bit colour tag, so the downstream writer can route it to the correct colour plane. New pixels keep shifting in while the held words go out. A frame-start pulse realigns packing to pixel 0.

The sequencer has five states. ST_IDLE waits. ST_RED, ST_GREEN and ST_BLUE each present one word. ST_GAP is the empty fourth cycle. The transitions are:
- ST_IDLE goes to ST_RED on a group capture and otherwise stays in ST_IDLE.
- ST_RED goes to ST_GREEN.
- ST_GREEN goes to ST_BLUE.
- ST_BLUE goes to ST_GAP.
- ST_GAP goes to ST_RED on a capture and otherwise goes to ST_IDLE.

Top module: `subfield_packer`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns after that edge to: no word valid, all flags low, and pixel position 0.
- R2: In each emitted word, the k-th accepted pixel of the group (k = 0..3) sits in bits [8k+7:8k]. The earliest pixel is in the least significant byte.
- R3: The red word appears with tag 0 and flag bit 0 in the first cycle after the clock edge that accepts the fourth pixel of a group.
- R4: The green word (tag 1, flag bit 1) follows in the next cycle. The blue word (tag 2, flag bit 2) follows in the cycle after that.
- R5: The cycle after the blue word carries no word, even when pixels arrive on every clock.
- R6: At most one flag is high. `word_valid` is high exactly when a flag is high, and the high flag bit equals the tag value.
- R7: A cycle with `pix_valid` low is ignored: its data is not packed and the pixel position does not advance.
- R8: `frame_start` clears the pixel position. A pixel presented in the same cycle as `frame_start` becomes pixel 0 of a new group.
- R9: Held words stay unchanged while new pixels shift in during their release, so a gapless stream yields correct words for every group.
- R10: A synchronous reset in the middle of a group discards the partial group. The next four pixels form a complete, aligned group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Pulse that realigns packing to pixel 0 |
| pix_valid | input | 1 | Qualifies the pixel inputs |
| pix_r | input | 8 | Red sample |
| pix_g | input | 8 | Green sample |
| pix_b | input | 8 | Blue sample |
| word_valid | output | 1 | A packed word is on `word_data` |
| word_data | output | 32 | Four samples of one colour |
| word_tag | output | 2 | Colour of the word: 0 red, 1 green, 2 blue |
| color_flags | output | 3 | One-hot colour select: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The hardest situation to reach is a new group completing exactly as the gap cycle of the previous release ends. In that case the shift paths are overwritten while held words are still being released. A gapless pixel stream is what forces this. The bench drives several back-to-back groups and a long stream with random valid bubbles. It places `frame_start` and a reset in the middle of groups, so that realigned groups also land on that boundary. A scoreboard predicts the data, tag and exact cycle of every word and confirms that the cycle after each blue word is empty.

// File: rtl/subfield_pkg.sv
package subfield_pkg;
    localparam int NUM_COLORS = 3;

    typedef enum logic [1:0] {
        TAG_RED   = 2'd0,
        TAG_GREEN = 2'd1,
        TAG_BLUE  = 2'd2
    } color_tag_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RED,
        ST_GREEN,
        ST_BLUE,
        ST_GAP
    } seq_state_e;
endpackage

// File: rtl/pixel_phase.sv
module pixel_phase #(
    parameter int LANES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic pix_valid,
    output logic group_done
);
    localparam int PH_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(LANES - 1);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] base;

    always_comb begin
        base       = frame_start ? '0 : phase;
        group_done = pix_valid && (base == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (pix_valid) begin
            phase <= (base == LAST) ? '0 : base + 1'b1;
        end else if (frame_start) begin
            phase <= '0;
        end
    end

    // R8
    fs_clears_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !pix_valid) |=> (phase == '0));

    // R7
    idle_holds_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!pix_valid && !frame_start) |=> $stable(phase));

    // R1
    reset_phase_chk: assert property (@(posedge clk)
        rst |=> (phase == '0));
endmodule

// File: rtl/lane_packer.sv
module lane_packer #(
    parameter int SAMPLE_W = 8,
    parameter int LANES    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        shift_en,
    input  logic                        load_hold,
    input  logic [SAMPLE_W-1:0]         sample_in,
    output logic [SAMPLE_W*LANES-1:0]   hold_word
);
    localparam int WORD_W = SAMPLE_W * LANES;

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shifted;

    // newest sample enters at the top; after LANES shifts the first is at the bottom
    assign shifted = {sample_in, shreg[WORD_W-1:SAMPLE_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            hold_word <= '0;
        end else begin
            if (shift_en) begin
                shreg <= shifted;
            end
            if (load_hold) begin
                hold_word <= shifted;
            end
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !load_hold |=> $stable(hold_word));
endmodule

// File: rtl/flag_sequencer.sv
module flag_sequencer
    import subfield_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  capture,
    output logic [NUM_COLORS-1:0] flags,
    output color_tag_e            tag,
    output logic                  emit
);
    seq_state_e state;
    seq_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = capture ? ST_RED : ST_IDLE;
            ST_RED:   state_nx = ST_GREEN;
            ST_GREEN: state_nx = ST_BLUE;
            ST_BLUE:  state_nx = ST_GAP;
            ST_GAP:   state_nx = capture ? ST_RED : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        flags = '0;
        tag   = TAG_RED;
        emit  = 1'b0;
        unique case (state)
            ST_IDLE, ST_GAP: begin
                flags = '0;
            end
            ST_RED: begin
                flags = 3'b001;
                tag   = TAG_RED;
                emit  = 1'b1;
            end
            ST_GREEN: begin
                flags = 3'b010;
                tag   = TAG_GREEN;
                emit  = 1'b1;
            end
            ST_BLUE: begin
                flags = 3'b100;
                tag   = TAG_BLUE;
                emit  = 1'b1;
            end
            default: flags = '0;
        endcase
    end

    // R3
    capture_starts_red_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> (flags == 3'b001));

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        capture |-> (state == ST_IDLE || state == ST_GAP));

    // R4
    red_then_green_chk: assert property (@(posedge clk) disable iff (rst)
        (flags == 3'b001) |=> (flags == 3'b010));

    // R4
    green_then_blue_chk: assert property (@(posedge clk) disable iff (rst)
        (flags == 3'b010) |=> (flags == 3'b100));

    // R5
    blue_then_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (flags == 3'b100) |=> (flags == 3'b000));

    // R6
    flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags));
endmodule

// File: rtl/subfield_packer.sv
module subfield_packer
    import subfield_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int LANES    = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_start,
    input  logic                      pix_valid,
    input  logic [SAMPLE_W-1:0]       pix_r,
    input  logic [SAMPLE_W-1:0]       pix_g,
    input  logic [SAMPLE_W-1:0]       pix_b,
    output logic                      word_valid,
    output logic [SAMPLE_W*LANES-1:0] word_data,
    output logic [1:0]                word_tag,
    output logic [NUM_COLORS-1:0]     color_flags
);
    localparam int WORD_W = SAMPLE_W * LANES;

    logic              group_done;
    logic [SAMPLE_W-1:0] samples [NUM_COLORS];
    logic [WORD_W-1:0]   held    [NUM_COLORS];
    color_tag_e          seq_tag;
    logic                seq_emit;

    assign samples[0] = pix_r;
    assign samples[1] = pix_g;
    assign samples[2] = pix_b;

    pixel_phase #(.LANES(LANES)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .pix_valid  (pix_valid),
        .group_done (group_done)
    );

    for (genvar c = 0; c < NUM_COLORS; c++) begin : g_lane
        lane_packer #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .shift_en (pix_valid),
            .load_hold(group_done),
            .sample_in(samples[c]),
            .hold_word(held[c])
        );
    end

    flag_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .capture(group_done),
        .flags  (color_flags),
        .tag    (seq_tag),
        .emit   (seq_emit)
    );

    always_comb begin
        word_data = '0;
        for (int c = 0; c < NUM_COLORS; c++) begin
            if (color_flags[c]) begin
                word_data = held[c];
            end
        end
    end

    assign word_valid = seq_emit;
    assign word_tag   = seq_tag;

    // R6
    valid_matches_flags_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid == (color_flags != '0));

    // R6
    tag_matches_flag_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> color_flags[word_tag]);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!word_valid && color_flags == '0));
endmodule

// File: tb/subfield_packer_test.sv
module subfield_packer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        word_valid;
    logic [31:0] word_data;
    logic [1:0]  word_tag;
    logic [2:0]  color_flags;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    logic [33:0] exp_q[$];
    int          exp_cyc_q[$];
    int          m_phase = 0;
    logic [31:0] m_word [3];
    bit          gap_pending = 0;

    subfield_packer uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .word_valid(word_valid), .word_data(word_data), .word_tag(word_tag),
        .color_flags(color_flags)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_pix(input logic v, input logic fs,
                            input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        @(negedge clk);
        pix_valid = v; frame_start = fs;
        pix_r = r; pix_g = g; pix_b = b;
        if (fs) m_phase = 0;
        if (v) begin
            m_word[0][8*m_phase +: 8] = r;
            m_word[1][8*m_phase +: 8] = g;
            m_word[2][8*m_phase +: 8] = b;
            m_phase++;
            if (m_phase == 4) begin
                for (int c = 0; c < 3; c++) begin
                    exp_q.push_back({c[1:0], m_word[c]});
                    exp_cyc_q.push_back(cyc + 1 + c);
                end
                m_phase = 0;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_pix(1'b0, 1'b0, 8'hEE, 8'hDD, 8'hCC);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pix_valid = 1'b0; frame_start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_phase = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (gap_pending) begin
                check(!word_valid, "R5", "gap cycle after blue", word_valid, 0);
                gap_pending = 0;
            end else if (word_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected word", word_data, 0);
                end else begin
                    logic [33:0] e;
                    int ec;
                    e  = exp_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    check(word_tag == e[33:32], "R3/R4", "tag", word_tag, e[33:32]);
                    check(word_data == e[31:0], "R2/R9", "data", word_data, e[31:0]);
                    check(cyc == ec, "R3/R4", "cycle", cyc, ec);
                    check(color_flags == (3'b001 << word_tag), "R6", "flags", color_flags,
                          3'b001 << word_tag);
                    if (word_tag == 2'd2) gap_pending = 1;
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!word_valid, "R1", "word_valid in reset", word_valid, 0);
        check(color_flags == 3'b000, "R1", "flags in reset", color_flags, 0);
        rst = 1'b0;
        idle(2);
        check(!word_valid, "R1", "word_valid after reset", word_valid, 0);

        // R2 R3 R4 R5 R9: gapless groups with distinct patterns
        for (int g = 0; g < 3; g++)
            for (int p = 0; p < 4; p++)
                send_pix(1'b1, 1'b0, 8'(16*g + p + 1), 8'(8'h40 + 16*g + p), 8'(8'hA0 + 16*g + p));
        idle(6);

        // R7: bubbles with garbage data inside a group
        send_pix(1'b1, 1'b0, 8'h11, 8'h22, 8'h33);
        idle(2);
        send_pix(1'b1, 1'b0, 8'h44, 8'h55, 8'h66);
        send_pix(1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF);
        send_pix(1'b1, 1'b0, 8'h77, 8'h88, 8'h99);
        idle(3);
        send_pix(1'b1, 1'b0, 8'hAA, 8'hBB, 8'hCC);
        idle(6);

        // R8: frame_start with a pixel mid-group
        send_pix(1'b1, 1'b0, 8'h01, 8'h02, 8'h03);
        send_pix(1'b1, 1'b0, 8'h04, 8'h05, 8'h06);
        send_pix(1'b1, 1'b1, 8'hC0, 8'hC1, 8'hC2);
        for (int p = 1; p < 4; p++) send_pix(1'b1, 1'b0, 8'(8'hC0 + 4*p), 8'(8'hD0 + p), 8'(8'hE0 + p));
        idle(6);

        // R8: frame_start without a pixel mid-group
        send_pix(1'b1, 1'b0, 8'h5A, 8'h5B, 8'h5C);
        send_pix(1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
        for (int p = 0; p < 4; p++) send_pix(1'b1, 1'b0, 8'(8'h30 + p), 8'(8'h60 + p), 8'(8'h90 + p));
        idle(6);

        // R10: reset mid-group
        send_pix(1'b1, 1'b0, 8'h12, 8'h34, 8'h56);
        send_pix(1'b1, 1'b0, 8'h78, 8'h9A, 8'hBC);
        do_reset();
        check(!word_valid, "R10", "no word after reset", word_valid, 0);
        for (int p = 0; p < 4; p++) send_pix(1'b1, 1'b0, 8'(8'h80 + p), 8'(8'h81 + p), 8'(8'h82 + p));
        idle(6);

        // R7 R9: long stream with random bubbles
        for (int i = 0; i < 400; i++)
            send_pix(($urandom % 4) != 0, 1'b0, 8'($urandom), 8'($urandom), 8'($urandom));
        idle(8 + 4 * (4 - m_phase));
        if (m_phase != 0) begin
            for (int p = m_phase; p < 4; p++) send_pix(1'b1, 1'b0, 8'(p), 8'(p + 1), 8'(p + 2));
            idle(8);
        end
        check(exp_q.size() == 0, "R3", "words still expected", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule